// File: doc/BRIEF.md
# Secure Key Fetch Engine

The engine builds a secret key out of a window of one-time-programmable rows. A single start pulse supplies the first row, the last row and the key length in 32-bit words. The engine then reads the rows one at a time, in ascending order, through an ECC-checked read port. A row that comes back flagged is passed over. Every clean row adds its low 32 bits to an internal key buffer, which the consumer reads through a combinational word port.

When the engine stops, it emits a one-cycle completion pulse and a pass/fail verdict. It stops when the requested word count has been collected or when the row window runs out. The verdict is negative if no key could plausibly have been programmed: every collected word is all ones, every collected word is zero, or the row pointer moved beyond the last row of the window. The OTP array itself is outside the block. It is reached through a valid/ready request channel and a response strobe that carries the data and two error flags.

Top module: `key_fetch_engine`

## Requirements
- R1: A start pulse seen while idle captures the first row, the last row and the length, and raises busy_o. A start pulse seen while busy has no effect on the rows read or on the verdict.
- R2: Rows are requested in strictly increasing order, beginning at the first row. Only one read is in flight at any time. A request holds its row stable until it is accepted by rd_req_ready_i.
- R3: Reading goes on while words are still needed and the row pointer is at or below the last row.
- R4: A row returned with rd_rsp_ecc_err_i high uses up its row index and adds no key word.
- R5: A row returned with rd_rsp_fail_i high uses up its row index and adds no key word.
- R6: Accepted words are stored at buffer indices 0, 1, 2, … in order of acceptance and can be read on key_rd_word_o. A length above KEY_WORDS is clamped to KEY_WORDS.
- R7: The verdict is fail when the bitwise AND of all accepted words is all ones.
- R8: The verdict is fail when the bitwise OR of all accepted words is zero.
- R9: The verdict is fail when the row pointer ends past the last row. This includes the case where the final word was read from the last row itself, and the case where the last row is the highest row address.
- R10: A length of zero finishes without issuing a read, and its verdict is fail. The same holds when the first row is above the last row.
- R11: done_o is high for exactly one cycle. pass_o keeps its value until the next accepted start, which clears it to 0.
- R12: Out of reset, busy_o, done_o, pass_o and rd_req_valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| start_row_i | input | ROW_W | First row of the window |
| end_row_i | input | ROW_W | Last row of the window |
| key_len_i | input | LEN_W | Key length in 32-bit words |
| rd_req_valid_o | output | 1 | Row read request |
| rd_req_ready_i | input | 1 | Request accepted |
| rd_req_row_o | output | ROW_W | Row index of the request |
| rd_rsp_valid_i | input | 1 | Response strobe |
| rd_rsp_data_i | input | DATA_W | Row data |
| rd_rsp_ecc_err_i | input | 1 | ECC error detected on the row |
| rd_rsp_fail_i | input | 1 | Fail bits set on the row |
| key_rd_idx_i | input | IDX_W | Key buffer read index |
| key_rd_word_o | output | DATA_W | Key buffer word at that index |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict, 1 = key accepted |

## Verification
The bench places error flags on chosen rows. A design that aborted on a flagged row, or that counted a flagged row as a word, would return too few or misplaced words. It also runs windows that end exactly as the last word is read, including a window at the top of the row space. A design that tested exhaustion on the remaining count, or whose row pointer wrapped, would report pass in these cases. Uniform all-ones and all-zero rows, a zero length and a reversed window all have to give fail. A start pulse sent in the middle of a fetch must not change the verdict or the read sequence.

// File: rtl/kfe_pkg.sv
package kfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT
  } kfe_state_e;
endpackage

// File: rtl/kfe_seq.sv
module kfe_seq
  import kfe_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int KEY_WORDS = 16,
  localparam int LEN_W    = $clog2(KEY_WORDS + 1),
  localparam int IDX_W    = $clog2(KEY_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] start_row_i,
  input  logic [ROW_W-1:0] end_row_i,
  input  logic [LEN_W-1:0] key_len_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [ROW_W-1:0] req_row_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_bad_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] widx_o,
  output logic             clear_o,
  output logic             finish_o,
  output logic             exhausted_o,
  output logic             busy_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(KEY_WORDS);

  kfe_state_e       state_q;
  logic [ROW_W:0]   row_q;   // one extra bit so the top row can be passed
  logic [ROW_W-1:0] end_q;
  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] widx_q;
  logic [LEN_W-1:0] len_eff;
  logic             more;

  assign len_eff     = (key_len_i > MAX_LEN) ? MAX_LEN : key_len_i;
  assign more        = (rem_q != '0) && (row_q <= {1'b0, end_q});
  assign clear_o     = (state_q == ST_IDLE) && start_i;
  assign finish_o    = (state_q == ST_CHECK) && !more;
  assign req_valid_o = (state_q == ST_REQ);
  assign req_row_o   = row_q[ROW_W-1:0];
  assign accept_o    = (state_q == ST_WAIT) && rsp_valid_i && !rsp_bad_i;
  assign widx_o      = widx_q;
  assign exhausted_o = row_q > {1'b0, end_q};
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      end_q   <= '0;
      rem_q   <= '0;
      widx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            row_q   <= {1'b0, start_row_i};
            end_q   <= end_row_i;
            rem_q   <= len_eff;
            widx_q  <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: state_q <= more ? ST_REQ : ST_IDLE;
        ST_REQ: begin
          if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            row_q <= row_q + (ROW_W + 1)'(1);
            if (!rsp_bad_i) begin
              rem_q  <= rem_q - LEN_W'(1);
              widx_q <= widx_q + IDX_W'(1);
            end
            state_q <= ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_row_o)));

  a_r2_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  a_r10_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o && key_len_i == '0) |=> (finish_o && !req_valid_o));

  a_r9_short_key_exhausted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_o && rem_q != '0) |-> exhausted_o);

  a_r1_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_CHECK) |=> $stable(end_q));
endmodule

// File: rtl/kfe_judge.sv
module kfe_judge #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              plausible_o
);
  logic [DATA_W-1:0] or_q, and_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      or_q  <= '0;
      and_q <= '1;
    end else if (clear_i) begin
      or_q  <= '0;
      and_q <= '1;
    end else if (acc_i) begin
      or_q  <= or_q | word_i;
      and_q <= and_q & word_i;
    end
  end

  assign plausible_o = (and_q != '1) && (or_q != '0);

  a_r7_and_only_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((and_q & ~$past(and_q)) == '0));

  a_r8_or_only_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (($past(or_q) & ~or_q) == '0));
endmodule

// File: rtl/kfe_key_buf.sv
module kfe_key_buf #(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 16,
  localparam int IDX_W    = $clog2(KEY_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [KEY_WORDS];

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rd_data_o = (int'(rd_idx_i) < KEY_WORDS) ? mem_q[rd_idx_i] : '0;

  a_r6_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(widx_i) < KEY_WORDS));
endmodule

// File: rtl/key_fetch_engine.sv
module key_fetch_engine #(
  parameter int ROW_W     = 10,
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 16,
  localparam int LEN_W    = $clog2(KEY_WORDS + 1),
  localparam int IDX_W    = $clog2(KEY_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  start_row_i,
  input  logic [ROW_W-1:0]  end_row_i,
  input  logic [LEN_W-1:0]  key_len_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ROW_W-1:0]  rd_req_row_o,
  input  logic              rd_rsp_valid_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  input  logic              rd_rsp_ecc_err_i,
  input  logic              rd_rsp_fail_i,
  input  logic [IDX_W-1:0]  key_rd_idx_i,
  output logic [DATA_W-1:0] key_rd_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);
  logic             accept, clear, finish, exhausted, plausible;
  logic [IDX_W-1:0] widx;

  kfe_seq #(.ROW_W(ROW_W), .KEY_WORDS(KEY_WORDS)) u_seq (
    .clk_i, .rst_ni, .start_i, .start_row_i, .end_row_i, .key_len_i,
    .req_valid_o (rd_req_valid_o),
    .req_ready_i (rd_req_ready_i),
    .req_row_o   (rd_req_row_o),
    .rsp_valid_i (rd_rsp_valid_i),
    .rsp_bad_i   (rd_rsp_ecc_err_i | rd_rsp_fail_i),
    .accept_o    (accept),
    .widx_o      (widx),
    .clear_o     (clear),
    .finish_o    (finish),
    .exhausted_o (exhausted),
    .busy_o      (busy_o)
  );

  kfe_judge #(.DATA_W(DATA_W)) u_judge (
    .clk_i, .rst_ni,
    .clear_i     (clear),
    .acc_i       (accept),
    .word_i      (rd_rsp_data_i),
    .plausible_o (plausible)
  );

  kfe_key_buf #(.DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_buf (
    .clk_i, .rst_ni,
    .we_i      (accept),
    .widx_i    (widx),
    .wdata_i   (rd_rsp_data_i),
    .rd_idx_i  (key_rd_idx_i),
    .rd_data_o (key_rd_word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (clear)       pass_o <= 1'b0;
      else if (finish) pass_o <= plausible && !exhausted;
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_pass_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!finish && !clear) |=> $stable(pass_o));

  a_r9_exhausted_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && exhausted) |=> !pass_o);
endmodule

// File: tb/key_fetch_engine_tb.sv
module key_fetch_engine_tb;
  localparam int ROW_W = 10, DATA_W = 32, KEY_WORDS = 16;
  localparam int LEN_W = $clog2(KEY_WORDS + 1), IDX_W = $clog2(KEY_WORDS);

  typedef struct packed {
    logic [9:0]  s;
    logic [9:0]  e;
    logic [4:0]  len;
    logic [31:0] ecc;
    logic [31:0] fl;
    logic [1:0]  mode;   // 0 pattern, 1 all ones, 2 all zeros
    logic        pass;
    logic [4:0]  words;
    logic [4:0]  reads;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{10'd10,   10'd20,   5'd4,  32'h0,        32'h0,    2'd0, 1'b1, 5'd4,  5'd4},
    '{10'd10,   10'd20,   5'd4,  32'h800,      32'h0,    2'd0, 1'b1, 5'd4,  5'd5},
    '{10'd10,   10'd20,   5'd4,  32'h0,        32'h3000, 2'd0, 1'b1, 5'd4,  5'd6},
    '{10'd5,    10'd8,    5'd4,  32'h0,        32'h0,    2'd0, 1'b0, 5'd4,  5'd4},
    '{10'd5,    10'd8,    5'd4,  32'h40,       32'h0,    2'd0, 1'b0, 5'd3,  5'd4},
    '{10'd0,    10'd3,    5'd2,  32'h0,        32'h0,    2'd1, 1'b0, 5'd2,  5'd2},
    '{10'd0,    10'd3,    5'd2,  32'h0,        32'h0,    2'd2, 1'b0, 5'd2,  5'd2},
    '{10'd3,    10'd9,    5'd0,  32'h0,        32'h0,    2'd0, 1'b0, 5'd0,  5'd0},
    '{10'd9,    10'd3,    5'd2,  32'h0,        32'h0,    2'd0, 1'b0, 5'd0,  5'd0},
    '{10'd30,   10'd40,   5'd3,  32'hC00001FF, 32'h0,    2'd0, 1'b0, 5'd0,  5'd11},
    '{10'd1000, 10'd1023, 5'd2,  32'h0,        32'h0,    2'd0, 1'b1, 5'd2,  5'd2},
    '{10'd1020, 10'd1023, 5'd4,  32'h0,        32'h0,    2'd0, 1'b0, 5'd4,  5'd4},
    '{10'd100,  10'd200,  5'd20, 32'h0,        32'h0,    2'd0, 1'b1, 5'd16, 5'd16}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ROW_W-1:0] start_row_i = '0, end_row_i = '0;
  logic [LEN_W-1:0] key_len_i = '0;
  logic rd_req_valid_o, rd_req_ready_i;
  logic [ROW_W-1:0] rd_req_row_o;
  logic rd_rsp_valid_i, rd_rsp_ecc_err_i, rd_rsp_fail_i;
  logic [DATA_W-1:0] rd_rsp_data_i;
  logic [IDX_W-1:0] key_rd_idx_i = '0;
  logic [DATA_W-1:0] key_rd_word_o;
  logic busy_o, done_o, pass_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] cur_ecc = '0, cur_fl = '0;
  logic [1:0]  cur_mode = '0;
  int exp_start = 0;
  logic clr_model = 1'b0;
  int nreads;
  logic row_err;
  int cyc;
  int lat;

  always #4 clk_i = ~clk_i;  // 125 MHz

  key_fetch_engine u_dut (.*);

  function automatic logic [31:0] row_data(int r, logic [1:0] m);
    logic [7:0] b;
    b = r[7:0];
    case (m)
      2'd1:    return 32'hFFFF_FFFF;
      2'd2:    return 32'h0;
      default: return {b, ~b, 16'hC3A5};
    endcase
  endfunction

  // OTP model: ready stalls one cycle in three, response two cycles after accept
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc <= 0; rd_req_ready_i <= 1'b0; rd_rsp_valid_i <= 1'b0;
      rd_rsp_data_i <= '0; rd_rsp_ecc_err_i <= 1'b0; rd_rsp_fail_i <= 1'b0;
      nreads <= 0; row_err <= 1'b0; lat <= 0;
    end else begin
      cyc <= cyc + 1;
      rd_req_ready_i <= (cyc % 3) != 1;
      rd_rsp_valid_i <= 1'b0;
      if (clr_model) begin nreads <= 0; row_err <= 1'b0; end
      if (rd_req_valid_o && rd_req_ready_i) begin
        if (int'(rd_req_row_o) != exp_start + nreads) row_err <= 1'b1;
        nreads <= nreads + 1;
        lat <= 2;
        rd_rsp_data_i    <= row_data(int'(rd_req_row_o), cur_mode);
        rd_rsp_ecc_err_i <= cur_ecc[rd_req_row_o[4:0]];
        rd_rsp_fail_i    <= cur_fl[rd_req_row_o[4:0]];
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) rd_rsp_valid_i <= 1'b1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk_i);
    cur_ecc = v.ecc; cur_fl = v.fl; cur_mode = v.mode; exp_start = int'(v.s);
    clr_model = 1'b1;
    @(negedge clk_i);
    clr_model = 1'b0;
    start_row_i = v.s; end_row_i = v.e; key_len_i = v.len; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(pass_o == 1'b0 && busy_o, "R11 pass cleared, R1 busy on start", {pass_o, busy_o}, 2'b01);
  endtask

  task automatic finish_vec(input vec_t v, input int vi);
    int guard = 0;
    int got = 0;
    while (!done_o && guard < 2000) begin @(negedge clk_i); guard++; end
    chk(done_o, $sformatf("R3 vec %0d completes", vi), done_o, 1);
    chk(pass_o == v.pass, $sformatf("R7 R8 R9 R10 vec %0d verdict", vi), pass_o, v.pass);
    chk(nreads == int'(v.reads), $sformatf("R3 R4 R5 vec %0d read count", vi), nreads, v.reads);
    chk(!row_err, $sformatf("R2 vec %0d row order", vi), row_err, 0);
    @(negedge clk_i);
    chk(!done_o && pass_o == v.pass, $sformatf("R11 vec %0d pulse/hold", vi), {done_o, pass_o}, {1'b0, v.pass});
    // R6: walk window, skip flagged rows, compare buffer words
    for (int r = int'(v.s); r <= int'(v.e) && got < int'(v.words); r++) begin
      if (!v.ecc[r % 32] && !v.fl[r % 32]) begin
        key_rd_idx_i = IDX_W'(got);
        #1;
        chk(key_rd_word_o == row_data(r, v.mode), $sformatf("R6 vec %0d word %0d", vi, got),
            key_rd_word_o, row_data(r, v.mode));
        got++;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !pass_o && !rd_req_valid_o, "R12 reset state",
        {busy_o, done_o, pass_o, rd_req_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      finish_vec(VECS[i], i);
    end

    // R1: start while busy is ignored
    launch(VECS[0]);
    repeat (3) @(negedge clk_i);
    start_row_i = 10'd0; end_row_i = 10'd1; key_len_i = '0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    finish_vec(VECS[0], 100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule